// File: doc/BRIEF.md
# Transmit Word Queue with Occupancy Flags

This block holds 12-bit words between a host that deposits them one at a time through a write strobe and a serial transmitter that removes them one at a time through a read strobe. It stores up to 32 words in first-in, first-out order. Words leave in the same order they arrived.

From its occupancy the block derives three flags: empty, exactly-half and full. They are packed into the upper three bits of a status byte. Two status outputs are also driven. One always follows the empty flag. The other follows either the full flag or the half flag, and a configuration input picks which. A write made while the queue is full is dropped. A read made while it is empty is ignored.

Top module: `txq_fifo`

## Requirements
- R1: After reset the queue holds no words, the status byte reads 0x20, `empty_o` is 1 and `flag_o` is 0.
- R2: Words are read out in the order they were written. A word removed by an accepted read appears on `rd_data` in the cycle after the read strobe's clock edge.
- R3: Status bit 5 (empty) is 1 exactly when no words are held.
- R4: Status bit 6 (half) is 1 exactly when 16 words are held, and 0 for every other count.
- R5: Status bit 7 (full) is 1 exactly when 32 words are held. The occupancy never goes above 32.
- R6: A write made while full is discarded, and the stored words are unchanged. A read in the same cycle is still accepted. Writes are accepted again from the first cycle in which full reads 0.
- R7: `empty_o` always equals status bit 5.
- R8: `flag_o` equals the half flag when `cfg_pin_sel` is 1, and the full flag when it is 0.
- R9: A read and a write in the same cycle, while the queue is neither empty nor full, leave the occupancy unchanged and both take effect.
- R10: A read while empty leaves `rd_data` at its previous value and does not move the read position. A write in the same cycle is still accepted.
- R11: Status bits 4 down to 0 always read 0.
- R12: Flags change in the cycle after the clock edge that alters the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from host |
| wr_data | input | 12 | Word to enqueue |
| rd_en | input | 1 | Read strobe from transmitter |
| rd_data | output | 12 | Most recently dequeued word |
| cfg_pin_sel | input | 1 | 1: `flag_o` shows half, 0: shows full |
| status | output | 8 | {full, half, empty, 5'b0} |
| empty_o | output | 1 | Empty flag |
| flag_o | output | 1 | Full or half flag, per `cfg_pin_sel` |

## Verification
The bench targets the counts at which a flag changes: 0 to 1 and back, 15, 16 and 17 for half, and 31 to 32 for full. A half flag built as "at least 16" would stay set above 16, and an off-by-one full flag would let a write overwrite the oldest word. That overwrite then shows up as wrong data when the queue is drained. Writes aimed at a full queue, reads from an empty queue, and read-write pairs at both extremes are driven as directed cases. A design that moved the read pointer on an empty read, or that let the write win when full, would return words out of order. Random traffic with a changing pin selection then covers ordering and the multiplexed output across many wraps of the pointers.

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             cfg_pin_sel,
  output logic [7:0]       status,
  output logic             empty_o,
  output logic             flag_o
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, cnt_nxt;
  logic             empty_q, half_q, full_q;
  logic             wr_ok, rd_ok;

  assign wr_ok   = wr_en & ~full_q;
  assign rd_ok   = rd_en & ~empty_q;
  assign cnt_nxt = count + CW'(wr_ok) - CW'(rd_ok);

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr] <= wr_data;

  // pointers wrap naturally: DEPTH is a power of two
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      empty_q <= 1'b1;
      half_q  <= 1'b0;
      full_q  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) begin
        rd_ptr  <= rd_ptr + 1'b1;
        rd_data <= mem[rd_ptr];
      end
      count   <= cnt_nxt;
      empty_q <= (cnt_nxt == '0);
      half_q  <= (cnt_nxt == CW'(HALF));
      full_q  <= (cnt_nxt == CW'(DEPTH));
    end
  end

  assign status  = {full_q, half_q, empty_q, 5'b0};
  assign empty_o = empty_q;
  assign flag_o  = cfg_pin_sel ? half_q : full_q;

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && wr_en && !rd_en) |=> ($stable(count) && $stable(wr_ptr)));

  p_half_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |-> (count == CW'(HALF)));

  p_rdwr_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !empty_q && !full_q) |=> $stable(count));

  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_q && rd_en) |=> ($stable(rd_data) && $stable(rd_ptr)));

  p_flags_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({empty_q, half_q, full_q}));

endmodule

// File: tb/txq_fifo_bench.sv
module txq_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, cfg_pin_sel = 1'b0;
  logic [11:0] wr_data = '0;
  logic [11:0] rd_data;
  logic [7:0]  status;
  logic        empty_o, flag_o;

  int tests = 0, fails = 0;
  logic [11:0] q [32];
  int head = 0, tail = 0, cnt = 0;
  logic [11:0] exp_rd = '0;
  bit done = 0;

  always #4 clk = ~clk;

  txq_fifo u_txq_fifo (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .cfg_pin_sel(cfg_pin_sel), .status(status),
    .empty_o(empty_o), .flag_o(flag_o));

  function automatic logic [7:0] exp_status(int c);
    return {c == 32, c == 16, c == 0, 5'b0};
  endfunction

  function automatic logic exp_flag(int c, logic sel);
    return sel ? (c == 16) : (c == 32);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (count %0d)", req, act, exp, cnt);
    end
  endtask

  task automatic check_all();
    chk(cnt == 16 ? "R4" : (cnt == 32 ? "R5" : "R3"), status, exp_status(cnt));
    chk("R11", status[4:0], 0);
    chk("R7", empty_o, status[5]);
    chk("R8", flag_o, exp_flag(cnt, cfg_pin_sel));
    chk("R2", rd_data, exp_rd);
  endtask

  // drive at negedge, let one posedge act, check at next negedge (R12)
  task automatic step(logic w, logic [11:0] d, logic r, logic sel);
    bit rok, wok;
    wr_en = w; wr_data = d; rd_en = r; cfg_pin_sel = sel;
    rok = r && cnt > 0;
    wok = w && cnt < 32;
    @(posedge clk);
    @(negedge clk);
    if (rok) begin exp_rd = q[head]; head = (head + 1) % 32; end
    if (wok) begin q[tail] = d; tail = (tail + 1) % 32; end
    cnt = cnt + int'(wok) - int'(rok);
    wr_en = 0; rd_en = 0;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", status, 8'h20);
    chk("R1", empty_o, 1);
    chk("R1", flag_o, 0);
    // R10: empty read ignored, then write+read at empty
    step(0, 0, 1, 1);
    step(1, 12'hA5A, 1, 1);
    chk("R10", cnt, 1);
    step(0, 0, 1, 0);
    chk("R10", rd_data, 12'hA5A);
    step(0, 0, 1, 0);
    chk("R10", rd_data, 12'hA5A);
    // fill to 32 with half pin selected, flip at 16 edges (R4)
    for (int i = 0; i < 32; i++) begin
      step(1, 12'(i * 97 + 5), 0, (i % 2) == 0);
      if (i == 15) begin chk("R4", status[6], 1); step(0, 0, 0, 1); chk("R8", flag_o, 1); end
      if (i == 16) chk("R4", status[6], 0);
    end
    chk("R5", status, 8'h80);
    step(0, 0, 0, 0);
    chk("R8", flag_o, 1);
    // R6: writes while full dropped
    for (int i = 0; i < 3; i++) step(1, 12'hFFF, 0, 0);
    chk("R6", cnt, 32);
    step(1, 12'hEEE, 1, 0);
    chk("R6", status[7], 0);
    step(1, 12'h123, 0, 0);
    chk("R6", status[7], 1);
    // R9 at mid level
    step(0, 0, 1, 1);
    step(1, 12'h321, 1, 1);
    chk("R9", cnt, 31);
    // drain fully (R2 data order checked each step)
    while (cnt > 0) step(0, 0, 1, $urandom_range(0, 1));
    chk("R3", status[5], 1);
    // random phases: write-biased, read-biased, balanced
    for (int ph = 0; ph < 12; ph++) begin
      int wp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 20 : 50;
      for (int k = 0; k < 250; k++)
        step($urandom_range(0, 99) < wp, 12'($urandom), $urandom_range(0, 99) >= wp - 10,
             $urandom_range(0, 3) == 0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule